// File: doc/BRIEF.md
# Lockable I2C Wiper Code Register

This block is the digital side of a 64-step programmable resistor. A host on a two-wire I2C bus writes a 6-bit wiper code, reads it back together with two status bits, and can finally issue a one-time program command. That command asks external fuse cells to burn the current code and freezes the register. The bus lines are sampled by a fast system clock, so no logic runs on SCL.

A write frame carries an address byte, an instruction byte and a data byte. The instruction byte selects one of four actions: a plain load, a return to the midscale code, shutdown of the resistor outputs, or the permanent program. A read frame returns one status-and-code byte, repeated for as long as the master keeps acknowledging. Once the part is locked, either by its own program command or by the fuse reporting that it is programmed, writes are still acknowledged but cannot move the code again. The shutdown control keeps working after the lock.

Top module: `wiper_otp_i2c`

## Requirements
- R1: The slave answers only the 7-bit address 0b010110 followed by the level of strap_i, with R/W as bit 0 of the byte. On a match it pulls SDA low in the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next START.
- R2: In a write frame the instruction byte and the data byte are each acknowledged. When instruction bits 7, 6 and 5 are all 0, data bits 5..0 become the wiper code, and data bits 7..6 are ignored. The code changes only once all eight data bits have arrived, so a frame that STOPs before its data byte leaves the code as it was.
- R3: Instruction bit 6 set, with bits 7 and 5 clear, loads the midscale code 0x20 and ignores the data byte.
- R4: Instruction bit 5 sets shutdown_o to 1, and any write frame with bit 5 clear sets it back to 0. A frame with bit 5 set leaves the wiper code unchanged.
- R5: Instruction bit 7 on an unlocked part raises fuse_req_o for exactly one clock and locks the part. The frozen code is the one held before the frame, and the data byte is ignored.
- R6: While the part is locked, either through R5 or because fuse_done_i is high, write frames are acknowledged but change neither the code nor the lock, and they raise no further fuse_req_o. Bit 5 still controls shutdown_o.
- R7: A read frame returns, MSB first, {E1, E0, code[5:0]}. E1 equals fuse_done_i. E0 is 1 when a program request has been issued and fuse_done_i is still low. When the master acknowledges, the same byte is sent again. When the master does not acknowledge, SDA is released.
- R8: After reset the wiper code is 0x20, shutdown_o is 0, fuse_req_o is 0, sda_oe_o is 0, and E1/E0 follow R7 with no request issued.
- R9: The slave only ever pulls SDA low. It drives SDA only for its acknowledges and for 0 bits of read data. A byte sent after the data byte of a write frame is not acknowledged.
- R10: The block operates correctly with SCL at 400 kHz and a 125 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 1 | Address strap, lowest address bit |
| fuse_done_i | input | 1 | Fuse cells report programmed |
| wiper_o | output | 6 | Current wiper code |
| shutdown_o | output | 1 | 1 opens the A end and ties the wiper to the B end |
| fuse_req_o | output | 1 | One-clock request to burn the fuses |

## Verification
Both bus lines pass through two synchroniser flops and one edge-detect flop. The FSM then reacts one clock later, so an acknowledge or a read bit reaches sda_oe_o about four system clocks after the SCL edge that causes it. The wiper code, shutdown_o and the one-clock fuse_req_o become valid a further clock after the falling edge that ends the eighth data bit. The bench holds each SCL phase for at least six system clocks. It samples acknowledges and read bits one quarter bit after SCL rises and checks the outputs only after STOP, so every result has settled before it is looked at. Program pulses are counted on every clock, which makes a stretched or repeated pulse visible as a count above one.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // instruction bits kept by the engine: instr[7:5]
  localparam int unsigned INS_KEEP_LSB = 5;
  localparam int unsigned IX_SD = 0;
  localparam int unsigned IX_RS = 1;
  localparam int unsigned IX_T  = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_INSTR, S_ACK_I,
    S_DATA, S_ACK_D, S_TX, S_MACK, S_IGN
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/wiper_i2c_engine.sv
module wiper_i2c_engine
  import wiper_pkg::*;
#(
  parameter logic [5:0]  ADDR_HI = 6'b010110,
  parameter int unsigned CODE_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              strap_i,
  input  logic [7:0]        rd_byte_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [2:0]        instr_o,
  output logic [CODE_W-1:0] data_o
);
  bus_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic              rw_q, mack_q, oe_q, stb_q;
  logic [2:0]        instr_q;
  logic [CODE_W-1:0] data_q;
  logic              rx_state;

  assign rx_state = (state_q == S_ADDR) || (state_q == S_INSTR) || (state_q == S_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      stb_q   <= 1'b0;
      instr_q <= '0;
      data_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start_i) begin
        state_q <= S_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= S_IDLE;
        oe_q    <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise_i && cnt_q != 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          cnt_q <= '0;
          if (state_q == S_ADDR) begin
            if (sh_q[7:1] == {ADDR_HI, strap_i}) begin
              oe_q    <= 1'b1;
              rw_q    <= sh_q[0];
              state_q <= S_ACK_A;
            end else begin
              state_q <= S_IGN;
            end
          end else if (state_q == S_INSTR) begin
            oe_q    <= 1'b1;
            instr_q <= sh_q[7:INS_KEEP_LSB];
            state_q <= S_ACK_I;
          end else begin
            oe_q    <= 1'b1;
            data_q  <= sh_q[CODE_W-1:0];
            stb_q   <= 1'b1;
            state_q <= S_ACK_D;
          end
        end
      end else begin
        unique case (state_q)
          S_ACK_A: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_byte_i;
              oe_q    <= ~rd_byte_i[7];
              state_q <= S_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= S_INSTR;
            end
          end
          S_ACK_I: if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= S_DATA;
          end
          S_ACK_D: if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= S_IGN;
          end
          S_TX: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= S_MACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
          S_MACK: begin
            if (scl_rise_i) mack_q <= ~sda_i;
            else if (scl_fall_i) begin
              if (mack_q) begin
                tx_q    <= rd_byte_i;
                oe_q    <= ~rd_byte_i[7];
                state_q <= S_TX;
              end else begin
                state_q <= S_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign wr_stb_o = stb_q;
  assign instr_o  = instr_q;
  assign data_o   = data_q;

  // R9: SDA is pulled only in acknowledge or transmit states
  a_r9_drive_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state_q inside {S_ACK_A, S_ACK_I, S_ACK_D, S_TX}));
  // R1: an ignored frame stays ignored until START or STOP
  a_r1_ignore_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IGN && !start_i && !stop_i) |=> (state_q == S_IGN));
  // R2: a write strobe only comes with the data-byte acknowledge
  a_r2_strobe_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (state_q == S_ACK_D && oe_q));
endmodule

// File: rtl/wiper_store.sv
module wiper_store
  import wiper_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [2:0]        instr_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              fuse_done_i,
  output logic [CODE_W-1:0] wiper_o,
  output logic              shutdown_o,
  output logic              fuse_req_o,
  output logic [1:0]        status_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] wiper_q;
  logic shutdown_q, lock_q, fuse_req_q, locked;

  assign locked = lock_q | fuse_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_q    <= MID;
      shutdown_q <= 1'b0;
      lock_q     <= 1'b0;
      fuse_req_q <= 1'b0;
    end else begin
      fuse_req_q <= 1'b0;
      if (wr_stb_i) begin
        shutdown_q <= instr_i[IX_SD];
        if (!locked) begin
          if (instr_i[IX_T]) begin
            lock_q     <= 1'b1;
            fuse_req_q <= 1'b1;
          end else if (instr_i[IX_SD]) begin
            wiper_q <= wiper_q;   // shutdown keeps the code
          end else if (instr_i[IX_RS]) begin
            wiper_q <= MID;
          end else begin
            wiper_q <= data_i;
          end
        end
      end
    end
  end

  assign wiper_o    = wiper_q;
  assign shutdown_o = shutdown_q;
  assign fuse_req_o = fuse_req_q;
  assign status_o   = {fuse_done_i, lock_q & ~fuse_done_i};

  a_r6_locked_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(wiper_q));
  a_r5_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_q |=> !fuse_req_q);
  a_r5_req_sets_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_q |-> lock_q);
  a_r6_single_program: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_req_q |-> !$past(locked));
  a_r4_sd_keeps_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_q) |-> $stable(wiper_q));
endmodule

// File: rtl/wiper_otp_i2c.sv
module wiper_otp_i2c #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  ADDR_HI     = 6'b010110
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       strap_i,
  input  logic       fuse_done_i,
  output logic [5:0] wiper_o,
  output logic       shutdown_o,
  output logic       fuse_req_o
);
  localparam int unsigned CODE_W = 6;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb;
  logic [2:0] instr;
  logic [CODE_W-1:0] data, wiper;
  logic [1:0] status;
  logic [7:0] rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  always_comb begin
    rd_byte = '0;
    rd_byte[7:6] = status;
    rd_byte[CODE_W-1:0] = wiper;
  end

  wiper_i2c_engine #(.ADDR_HI(ADDR_HI), .CODE_W(CODE_W)) u_engine (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .strap_i, .rd_byte_i(rd_byte),
    .sda_oe_o, .wr_stb_o(wr_stb), .instr_o(instr), .data_o(data)
  );

  wiper_store #(.CODE_W(CODE_W)) u_store (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .instr_i(instr), .data_i(data),
    .fuse_done_i, .wiper_o(wiper), .shutdown_o, .fuse_req_o, .status_o(status)
  );

  assign wiper_o = wiper;
endmodule

// File: tb/wiper_otp_i2c_test.sv
module wiper_otp_i2c_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, sda_m, strap, fuse_done;
  logic sda_oe, sd, req;
  logic [5:0] wiper;
  wire sda_line = sda_m & ~sda_oe;

  wiper_otp_i2c uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .fuse_done_i(fuse_done), .wiper_o(wiper),
    .shutdown_o(sd), .fuse_req_o(req)
  );

  int checks = 0, fails = 0, q = 6, req_cycles = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n && req) req_cycles++;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(q);
    scl = 1'b1; tick(q);
    sda_m = 1'b0; tick(q);
    scl = 1'b0; tick(q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(q);
    scl = 1'b1; tick(q);
    sda_m = 1'b1; tick(2 * q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(q);
      scl = 1'b1; tick(2 * q);
      scl = 1'b0; tick(q);
    end
    sda_m = 1'b1; tick(q);
    scl = 1'b1; tick(q);
    ack = (sda_line == 1'b0);
    tick(q);
    scl = 1'b0; tick(q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(q);
      scl = 1'b1; tick(q);
      b[i] = sda_line;
      tick(q);
      scl = 1'b0; tick(q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(q);
    scl = 1'b1; tick(2 * q);
    scl = 1'b0; tick(q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_of(logic a, logic rd);
    return {6'b010110, a, rd};
  endfunction

  task automatic write_frame(input logic [7:0] ab, ins, dat, output logic ok);
    logic k;
    ok = 1'b1;
    bus_start;
    send_byte(ab, k);  ok &= k;
    send_byte(ins, k); ok &= k;
    send_byte(dat, k); ok &= k;
    bus_stop;
  endtask

  task automatic read_frame(output logic [7:0] b, output logic ok);
    bus_start;
    send_byte(addr_of(strap, 1'b1), ok);
    recv_byte(b, 1'b0);
    bus_stop;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary;
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [7:0] rb, rb2;
    int exp_code;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 1'b0; fuse_done = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R8 reset state
    chk("R8 wiper", wiper, 8'h20);
    chk("R8 shutdown", sd, 0);
    chk("R8 fuse_req", req, 0);
    chk("R8 sda_oe", sda_oe, 0);
    read_frame(rb, ok);
    chk("R8 read ack", ok, 1);
    chk("R8 R7 read after reset", rb, 8'h20);

    // R2/R7 sweep of every code, both strap levels, don't-care top bits varied
    for (int c = 0; c < 64; c++) begin
      strap = c[0];
      write_frame(addr_of(strap, 1'b0), 8'h00, {c[2:1], c[5:0]}, ok);
      chk("R2 R1 sweep acks", ok, 1);
      chk("R2 sweep code", wiper, c);
      read_frame(rb, ok);
      chk("R7 sweep read", rb, c);
    end
    strap = 1'b1;
    exp_code = 63;

    // R1 mismatched strap and mismatched high bits
    write_frame(addr_of(1'b0, 1'b0), 8'h00, 8'h05, ok);
    chk("R1 strap mismatch no ack", ok, 0);
    chk("R1 strap mismatch code", wiper, exp_code);
    write_frame(8'h5E, 8'h00, 8'h06, ok);
    chk("R1 high bit mismatch no ack", ok, 0);
    chk("R1 high bit mismatch code", wiper, exp_code);

    // R2 STOP before data byte
    bus_start;
    send_byte(addr_of(strap, 1'b0), k);
    send_byte(8'h00, k);
    bus_stop;
    chk("R2 partial frame code", wiper, exp_code);

    // R3 midscale
    write_frame(addr_of(strap, 1'b0), 8'h40, 8'h3F, ok);
    chk("R3 rs code", wiper, 8'h20);

    // R4 shutdown keeps code, then cleared
    write_frame(addr_of(strap, 1'b0), 8'h20, 8'h05, ok);
    chk("R4 sd set", sd, 1);
    chk("R4 sd code kept", wiper, 8'h20);
    write_frame(addr_of(strap, 1'b0), 8'h00, 8'h11, ok);
    chk("R4 sd cleared", sd, 0);
    chk("R4 load after sd", wiper, 8'h11);

    // R9 extra byte after data not acknowledged
    bus_start;
    send_byte(addr_of(strap, 1'b0), k);
    send_byte(8'h00, k);
    send_byte(8'h0A, k);
    send_byte(8'h15, k);
    bus_stop;
    chk("R9 extra byte nack", k, 0);
    chk("R9 extra byte code", wiper, 8'h0A);
    chk("R9 released", sda_oe, 0);

    // R7 master ack repeats byte
    bus_start;
    send_byte(addr_of(strap, 1'b1), k);
    recv_byte(rb, 1'b1);
    recv_byte(rb2, 1'b0);
    bus_stop;
    chk("R7 first byte", rb, 8'h0A);
    chk("R7 repeated byte", rb2, 8'h0A);
    chk("R7 released after nack", sda_oe, 0);

    // R10 400 kHz bus
    q = 78;
    write_frame(addr_of(strap, 1'b0), 8'h00, 8'h2A, ok);
    chk("R10 acks", ok, 1);
    chk("R10 code", wiper, 8'h2A);
    read_frame(rb, ok);
    chk("R10 read", rb, 8'h2A);
    q = 6;

    // R5 program
    write_frame(addr_of(strap, 1'b0), 8'h80, 8'h3F, ok);
    chk("R5 acks", ok, 1);
    chk("R5 one-cycle request", req_cycles, 1);
    chk("R5 code frozen", wiper, 8'h2A);
    read_frame(rb, ok);
    chk("R5 R7 pending status", rb, 8'h6A);

    // R6 locked
    write_frame(addr_of(strap, 1'b0), 8'h00, 8'h01, ok);
    chk("R6 locked ack", ok, 1);
    chk("R6 locked load ignored", wiper, 8'h2A);
    write_frame(addr_of(strap, 1'b0), 8'h40, 8'h00, ok);
    chk("R6 locked rs ignored", wiper, 8'h2A);
    write_frame(addr_of(strap, 1'b0), 8'h80, 8'h00, ok);
    chk("R6 no second request", req_cycles, 1);
    write_frame(addr_of(strap, 1'b0), 8'h20, 8'h00, ok);
    chk("R6 sd honoured", sd, 1);
    chk("R6 sd code", wiper, 8'h2A);
    fuse_done = 1'b1;
    tick(4);
    read_frame(rb, ok);
    chk("R7 fuse done status", rb, 8'hAA);

    // R6 lock from fuse after reset
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk("R8 reset code", wiper, 8'h20);
    chk("R8 reset sd", sd, 0);
    write_frame(addr_of(strap, 1'b0), 8'h00, 8'h05, ok);
    chk("R6 fuse lock ack", ok, 1);
    chk("R6 fuse lock code", wiper, 8'h20);
    read_frame(rb, ok);
    chk("R7 fuse status after reset", rb, 8'hA0);
    chk("R6 no request under fuse lock", req_cycles, 1);

    done = 1;
    summary;
    $finish;
  end
endmodule